// File: doc/BRIEF.md
# Serial DAC Input Register

This block is the digital receive side of a 14-bit voltage-output converter. A host sends 16-bit words over a three-wire serial link made of an active-low chip select, a serial clock and a data line. Each word holds a 14-bit code, most significant bit first, followed by two trailing bits that should be zero. The block shifts the word in and checks that exactly sixteen clocks arrived while chip select was low. It then moves the code into a parallel latch that drives the converter.

A static mode strap picks how the transfer into the latch happens. With the strap low, releasing chip select loads the latch directly. With the strap high, a received word waits in a pending register. A falling edge on a separate active-low load strobe then copies it into the latch, and the block only acts on that edge while chip select is high. All pins are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and the block finds edges by comparing each synchronised level with its value one cycle earlier. Reset clears the latch to code zero.

Top module: `serial_dac_frontend`

## Requirements
- R1: After reset the latch `code_q` is 0, and `update_pulse`, `frame_err` and `subbit_nz` are all 0.
- R2: While chip select is low, each rising serial-clock edge shifts one data bit in. The first bit received is code bit 13, and bit 14 and bit 15 of the frame are the two trailing bits.
- R3: With `mode_pin` = 0, a chip-select rise after exactly 16 clocks loads the 14 code bits into `code_q`.
- R4: A chip-select rise after fewer than 16 clocks leaves `code_q` and any pending word unchanged. It sets `frame_err`, which stays 1 until reset, including across later valid frames.
- R5: The bit count saturates at 16. Clocks beyond the sixteenth are ignored, and the frame is still accepted with the first 16 bits.
- R6: Every accepted frame sets `subbit_nz` to 1 when either trailing bit is 1 and clears it to 0 when both are 0. The code is loaded in both cases.
- R7: With `mode_pin` = 1, a valid chip-select rise leaves `code_q` unchanged and stores the word as pending. A later falling edge of `load_n_pin`, seen while chip select is high, copies the pending code into `code_q`.
- R8: With `mode_pin` = 1, a load-strobe fall while no word is pending is ignored. This includes a second strobe after the pending word has already been used.
- R9: A load-strobe fall while chip select is low is ignored, and the pending word stays available for a later strobe.
- R10: With `mode_pin` = 0, the load strobe has no effect on `code_q` or `update_pulse`.
- R11: Serial-clock edges while chip select is high do not shift data and do not count toward the next frame.
- R12: Every change of `code_q` comes with `update_pulse` high for exactly one cycle, and `update_pulse` never rises without a latch load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_pin | input | 1 | Chip select from the host, active low, asynchronous |
| sck_pin | input | 1 | Serial clock, data sampled on its rising edge |
| sdi_pin | input | 1 | Serial data, MSB first |
| load_n_pin | input | 1 | Load strobe, acts on its falling edge in strobe mode |
| mode_pin | input | 1 | Strap: 0 loads on chip-select release, 1 loads on strobe |
| code_q | output | 14 | Parallel code held for the converter |
| update_pulse | output | 1 | One-cycle pulse when `code_q` is loaded |
| frame_err | output | 1 | Sticky flag for a frame with the wrong clock count |
| subbit_nz | output | 1 | Last accepted frame had a non-zero trailing bit |

## Verification
The embedded properties assume the pins move slowly compared with the system clock. Every level must last at least two synchronised cycles, so a single change never produces two edge detections. Chip select, the serial clock and the strobe must not change in the same synchronised cycle, and the mode strap must stay fixed while a frame or strobe is in flight. The stimulus meets these assumptions in three ways. It holds each pin level for four or more system clocks. It changes only one pin at a time on the falling system-clock edge. It changes the strap only while the link is idle, then waits before sending the next frame.

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend #(
  parameter int CODE_W = 14,
  parameter int SUB_W  = 2,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_pin,
  input  logic              sck_pin,
  input  logic              sdi_pin,
  input  logic              load_n_pin,
  input  logic              mode_pin,
  output logic [CODE_W-1:0] code_q,
  output logic              update_pulse,
  output logic              frame_err,
  output logic              subbit_nz
);
  localparam int FRAME_W = CODE_W + SUB_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);
  // pin order in vectors: {mode, load_n, sdi, sck, cs_n}
  localparam logic [4:0] IDLE = 5'b01001;

  logic [SYNC_N-1:0][4:0] sync;
  logic [4:0] s, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= {SYNC_N{IDLE}};
      prev <= IDLE;
    end else begin
      sync <= {sync[SYNC_N-2:0], {mode_pin, load_n_pin, sdi_pin, sck_pin, cs_n_pin}};
      prev <= s;
    end
  end

  assign s = sync[SYNC_N-1];

  logic cs_high, cs_fall, cs_rise, sck_rise, load_fall, mode4, sdi;
  assign cs_high   = s[0];
  assign cs_fall   = !s[0] && prev[0];
  assign cs_rise   = s[0] && !prev[0];
  assign sck_rise  = s[1] && !prev[1];
  assign sdi       = s[2];
  assign load_fall = !s[3] && prev[3];
  assign mode4     = s[4];

  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
    end else if (!cs_high && sck_rise && bit_cnt != FULL) begin
      shreg   <= {shreg[FRAME_W-2:0], sdi};
      bit_cnt <= bit_cnt + 1'b1;
    end
  end

  logic frame_ok, frame_bad;
  assign frame_ok  = cs_rise && bit_cnt == FULL;
  assign frame_bad = cs_rise && bit_cnt != FULL;

  logic [CODE_W-1:0] pend;
  logic              pend_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q       <= '0;
      pend         <= '0;
      pend_v       <= 1'b0;
      update_pulse <= 1'b0;
      frame_err    <= 1'b0;
      subbit_nz    <= 1'b0;
    end else begin
      update_pulse <= 1'b0;
      if (frame_bad) frame_err <= 1'b1;
      if (frame_ok) begin
        subbit_nz <= |shreg[SUB_W-1:0];
        if (mode4) begin
          pend   <= shreg[FRAME_W-1:SUB_W];
          pend_v <= 1'b1;
        end else begin
          code_q       <= shreg[FRAME_W-1:SUB_W];
          update_pulse <= 1'b1;
        end
      end else if (mode4 && load_fall && cs_high && pend_v) begin
        code_q       <= pend;
        pend_v       <= 1'b0;
        update_pulse <= 1'b1;
      end
    end
  end

  // R12
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    update_pulse |=> !update_pulse);

  // R12
  latch_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> update_pulse);

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  // R9
  load_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(code_q) |-> $past(cs_high));

  // R8
  pend_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (update_pulse && $past(mode4)) |-> !pend_v);

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == FULL && !cs_fall) |=> bit_cnt == FULL);
endmodule

// File: tb/serial_dac_frontend_bench.sv
module serial_dac_frontend_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, load_n = 1'b1, mode = 1'b0;
  logic [13:0] code_q;
  logic update_pulse, frame_err, subbit_nz;

  int checks = 0, failures = 0, pulses = 0, run_len = 0, max_run = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_dac_frontend u_serial_dac_frontend (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sck_pin(sck), .sdi_pin(sdi),
    .load_n_pin(load_n), .mode_pin(mode), .code_q(code_q),
    .update_pulse(update_pulse), .frame_err(frame_err), .subbit_nz(subbit_nz));

  always @(negedge clk) begin
    if (update_pulse) begin
      pulses  <= pulses + 1;
      run_len <= run_len + 1;
      if (run_len + 1 > max_run) max_run <= run_len + 1;
    end else run_len <= 0;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [15:0] w, input int nbits);
    cs_n = 1'b0; tick(4);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b1;
      tick(4); sck = 1'b1; tick(4); sck = 1'b0;
    end
    tick(4); cs_n = 1'b1; tick(10);
  endtask

  task automatic strobe();
    load_n = 1'b0; tick(6); load_n = 1'b1; tick(10);
  endtask

  task automatic t_reset();
    check("R1 code", code_q, 0);
    check("R1 pulse", update_pulse, 0);
    check("R1 err", frame_err, 0);
    check("R1 sub", subbit_nz, 0);
  endtask

  task automatic t_basic();
    int p0 = pulses;
    send_frame({14'h1A5C, 2'b00}, 16);
    check("R2 R3 code", code_q, 14'h1A5C);
    check("R12 one pulse", pulses - p0, 1);
    check("R6 sub clear", subbit_nz, 0);
    check("R1 no err yet", frame_err, 0);
  endtask

  task automatic t_short();
    int p0 = pulses;
    send_frame({14'h0F0F, 2'b00}, 10);
    check("R4 code kept", code_q, 14'h1A5C);
    check("R4 err set", frame_err, 1);
    check("R4 no pulse", pulses - p0, 0);
  endtask

  task automatic t_subbits();
    send_frame({14'h3FFF, 2'b01}, 16);
    check("R6 code loaded", code_q, 14'h3FFF);
    check("R6 sub flag", subbit_nz, 1);
    check("R4 err sticky", frame_err, 1);
  endtask

  task automatic t_long();
    send_frame({14'h0001, 2'b00}, 19);
    check("R5 code", code_q, 14'h0001);
    check("R5 R6 sub", subbit_nz, 0);
  endtask

  task automatic t_idle_clocks();
    sdi = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick(4); sck = 1'b1; tick(4); sck = 1'b0;
    end
    tick(6);
    send_frame({14'h2000, 2'b00}, 16);
    check("R11 code", code_q, 14'h2000);
    check("R11 sub", subbit_nz, 0);
  endtask

  task automatic t_strobe_3wire();
    int p0 = pulses;
    strobe();
    check("R10 code", code_q, 14'h2000);
    check("R10 pulse", pulses - p0, 0);
  endtask

  task automatic t_four_wire();
    int p0;
    mode = 1'b1; tick(10);
    p0 = pulses;
    strobe();
    check("R8 empty strobe code", code_q, 14'h2000);
    check("R8 empty strobe pulse", pulses - p0, 0);
    send_frame({14'h0ABC, 2'b00}, 16);
    check("R7 no load on cs", code_q, 14'h2000);
    check("R7 no pulse on cs", pulses - p0, 0);
    cs_n = 1'b0; tick(6); load_n = 1'b0; tick(6); load_n = 1'b1; tick(6);
    cs_n = 1'b1; tick(10);
    check("R9 code kept", code_q, 14'h2000);
    check("R9 no pulse", pulses - p0, 0);
    strobe();
    check("R7 strobe load", code_q, 14'h0ABC);
    check("R7 pulse", pulses - p0, 1);
    strobe();
    check("R8 reused strobe", pulses - p0, 1);
    check("R8 code kept", code_q, 14'h0ABC);
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(6);
    t_reset();
    t_basic();
    t_short();
    t_subbits();
    t_long();
    t_idle_clocks();
    t_strobe_3wire();
    t_four_wire();
    check("R12 pulse width", max_run, 1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule